// File: doc/BRIEF.md
# Two-Way Instruction Cache Controller

This block is a read-only instruction cache controller with two ways. A fetch request brings three things: a set index taken from the virtual address, a tag taken from the physical address, and a 2-bit instruction-set mode. On a hit the block returns one 32-bit fetch word. Each line is 64 bytes, which is sixteen words. A line holds code of one instruction-set mode only. If the same 64-byte region is fetched under two modes, it lives in two separate lines.

On a miss the block does the following:
- It sends one line request to a memory port. The request address names the word the fetch asked for.
- It accepts sixteen beats in wrap-around order, starting with that word.
- It forwards the first beat to the fetch output as soon as that beat arrives.
- It writes the line into a victim way. An empty way is used first. When both ways hold valid lines, the choice comes from a free-running LFSR.

Tags and data words carry even parity. A parity error invalidates the line and turns the access into a miss, so the line is fetched again. An error-injection input lets a test flip a stored bit.

Top module: `icache_ctrl`

## Requirements
- R1: A fetch that hits returns its word with `rsp_valid` high in the cycle after the request handshake. `rsp_valid` is never high unless a handshake or a first fill beat was accepted in the previous cycle.
- R2: A miss raises `mem_req_valid` with address {tag, index, requested word, 2'b00}. That address stays stable until accepted. `req_ready` stays low from the miss until the last beat of the line is accepted.
- R3: The k-th accepted fill beat (k = 0..15) is stored at word (requested word + k) mod 16. After the fill, every word of the line hits with the right data. No more than 16 beats are accepted per line request.
- R4: The first fill beat is forwarded: `rsp_valid` rises in the cycle after that beat is accepted, and `rsp_data` carries it.
- R5: Mode is part of the match (0 = 64-bit ISA, 1 = 32-bit fixed-length ISA, 2 = compressed ISA). The same address fetched with another mode misses, and is then cached as a second line.
- R6: When a set has an invalid way, the miss fills it without evicting the valid line. Two lines of one set then both hit.
- R7: When both ways are valid, the victim comes from bit 0 of a 16-bit LFSR (taps 16, 14, 13, 11) that advances every cycle. The new line hits and exactly one old line is evicted.
- R8: A single-bit error in a stored tag (`inj_data_sel` = 0 flips tag bit 0) is caught by parity. The access misses, the line is refetched, and the refetched line then hits.
- R9: A single-bit error in a stored data word (`inj_data_sel` = 1 flips data bit 0 of the word selected by `inj_word`) is caught by parity, with the same invalidate-and-refetch outcome as R8.
- R10: A one-cycle pulse on `inv_all` clears every valid bit, so the next fetch of a cached line misses.
- R11: After reset `req_ready` is 1, and `rsp_valid` and `mem_req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inv_all | input | 1 | Clear all valid bits |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Controller idle, able to take a fetch |
| req_index | input | 6 | Set index from the virtual address |
| req_word | input | 4 | Word offset within the line |
| req_ptag | input | 20 | Physical tag |
| req_mode | input | 2 | Instruction-set mode |
| rsp_valid | output | 1 | Fetch word valid (one-cycle pulse) |
| rsp_data | output | 32 | Fetch word |
| mem_req_valid | output | 1 | Line request valid |
| mem_req_ready | input | 1 | Line request accepted |
| mem_req_addr | output | 32 | Byte address of the critical word |
| fill_valid | input | 1 | Fill beat valid |
| fill_ready | output | 1 | Controller is taking fill beats |
| fill_data | input | 32 | Fill beat data |
| inj_valid | input | 1 | Flip one stored bit this cycle |
| inj_data_sel | input | 1 | 1: data word, 0: tag entry |
| inj_way | input | 1 | Way to corrupt |
| inj_index | input | 6 | Set to corrupt |
| inj_word | input | 4 | Word to corrupt (data only) |

## Verification
Fetch patterns are built to separate outcomes that would otherwise look alike:
- **Cold misses with a non-zero critical word** show wrapped fill order and forwarding timing. The fill carries gaps between beats, so a design that forwards a fixed beat or stores beats linearly gives wrong data on the later sweep over all sixteen words.
- **Same address under two modes** tells mode-aware matching apart from plain tag matching. It also checks that the empty way is taken before the random choice.
- **A third line in a full set, repeated over sixteen sets,** separates a random victim from a fixed one, since both ways must be evicted at least once.
- **Injected tag and data flips, followed by invalidate-all,** separate a parity refetch and a clear from stale hits.

// File: rtl/icache_pkg.sv
package icache_pkg;

  typedef enum logic [1:0] {
    ISA_WIDE  = 2'd0,
    ISA_FIXED = 2'd1,
    ISA_COMP  = 2'd2
  } isa_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MREQ = 2'd1,
    ST_FILL = 2'd2
  } fill_state_e;

  localparam int WORD_W = 32;

endpackage

// File: rtl/icache_lfsr.sv
module icache_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic clk,
  input  logic rst,
  output logic pick
);
  logic [15:0] q;
  logic        fb;

  // taps 16,14,13,11
  assign fb = q[15] ^ q[13] ^ q[12] ^ q[10];

  always_ff @(posedge clk) begin
    if (rst) q <= SEED;
    else     q <= {q[14:0], fb};
  end

  assign pick = q[0];
endmodule

// File: rtl/icache_tag_ram.sv
module icache_tag_ram #(
  parameter int TAG_W = 20,
  parameter int SETS  = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [$clog2(SETS)-1:0]  rd_idx,
  output logic                     rd_valid,
  output logic [TAG_W-1:0]         rd_tag,
  output logic [1:0]               rd_mode,
  output logic                     rd_perr,
  input  logic                     wr_en,
  input  logic [$clog2(SETS)-1:0]  wr_idx,
  input  logic [TAG_W-1:0]         wr_tag,
  input  logic [1:0]               wr_mode,
  input  logic                     vset_en,
  input  logic [$clog2(SETS)-1:0]  vset_idx,
  input  logic                     vclr_en,
  input  logic [$clog2(SETS)-1:0]  vclr_idx,
  input  logic                     clr_all,
  input  logic                     flip_en,
  input  logic [$clog2(SETS)-1:0]  flip_idx
);
  localparam int ENT_W = TAG_W + 2;

  logic [ENT_W-1:0] ent_q [SETS];
  logic [SETS-1:0]  par_q;
  logic [SETS-1:0]  val_q;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      ent_q[wr_idx] <= {wr_mode, wr_tag};
      par_q[wr_idx] <= ^{wr_mode, wr_tag};
    end else if (flip_en) begin
      ent_q[flip_idx][0] <= ~ent_q[flip_idx][0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr_all) begin
      val_q <= '0;
    end else begin
      if (vclr_en) val_q[vclr_idx] <= 1'b0;
      if (vset_en) val_q[vset_idx] <= 1'b1;
    end
  end

  assign rd_valid          = val_q[rd_idx];
  assign {rd_mode, rd_tag} = ent_q[rd_idx];
  assign rd_perr           = (^ent_q[rd_idx]) ^ par_q[rd_idx];
endmodule

// File: rtl/icache_data_ram.sv
module icache_data_ram #(
  parameter int SETS  = 64,
  parameter int WORDS = 16
) (
  input  logic                             clk,
  input  logic [$clog2(SETS*WORDS)-1:0]    rd_addr,
  output logic [31:0]                      rd_data,
  output logic                             rd_perr,
  input  logic                             wr_en,
  input  logic [$clog2(SETS*WORDS)-1:0]    wr_addr,
  input  logic [31:0]                      wr_data,
  input  logic                             flip_en,
  input  logic [$clog2(SETS*WORDS)-1:0]    flip_addr
);
  localparam int DEPTH = SETS * WORDS;

  logic [32:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en)        mem_q[wr_addr]      <= {^wr_data, wr_data};
    else if (flip_en) mem_q[flip_addr][0] <= ~mem_q[flip_addr][0];
  end

  assign rd_data = mem_q[rd_addr][31:0];
  assign rd_perr = ^mem_q[rd_addr];
endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int TAG_W = 20,
  parameter int SETS  = 64,
  parameter int WORDS = 16
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 inv_all,
  input  logic                                 req_valid,
  output logic                                 req_ready,
  input  logic [$clog2(SETS)-1:0]              req_index,
  input  logic [$clog2(WORDS)-1:0]             req_word,
  input  logic [TAG_W-1:0]                     req_ptag,
  input  logic [1:0]                           req_mode,
  output logic                                 rsp_valid,
  output logic [31:0]                          rsp_data,
  output logic                                 mem_req_valid,
  input  logic                                 mem_req_ready,
  output logic [TAG_W+$clog2(SETS)+$clog2(WORDS)+1:0] mem_req_addr,
  input  logic                                 fill_valid,
  output logic                                 fill_ready,
  input  logic [31:0]                          fill_data,
  input  logic                                 inj_valid,
  input  logic                                 inj_data_sel,
  input  logic                                 inj_way,
  input  logic [$clog2(SETS)-1:0]              inj_index,
  input  logic [$clog2(WORDS)-1:0]             inj_word
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WRD_W = $clog2(WORDS);
  localparam int NWAYS = 2;
  localparam logic [WRD_W-1:0] LAST_BEAT = WRD_W'(WORDS - 1);

  fill_state_e        st_q;
  logic [IDX_W-1:0]   m_idx;
  logic [WRD_W-1:0]   m_word;
  logic [TAG_W-1:0]   m_tag;
  logic [1:0]         m_mode;
  logic               vic_q;
  logic [WRD_W-1:0]   beat_q;
  logic               rsp_valid_q;
  logic [31:0]        rsp_data_q;

  logic [NWAYS-1:0]   t_val, t_perr, d_perr, match, bad, hit_w;
  logic [TAG_W-1:0]   t_tag  [NWAYS];
  logic [1:0]         t_mode [NWAYS];
  logic [31:0]        d_word [NWAYS];

  logic               accept, any_hit, fill_acc, first_beat, last_beat;
  logic               vic_c, lfsr_pick;
  logic [31:0]        hit_data;
  logic [WRD_W-1:0]   fill_word;

  assign req_ready     = (st_q == ST_IDLE);
  assign mem_req_valid = (st_q == ST_MREQ);
  assign fill_ready    = (st_q == ST_FILL);
  assign mem_req_addr  = {m_tag, m_idx, m_word, 2'b00};
  assign rsp_valid     = rsp_valid_q;
  assign rsp_data      = rsp_data_q;

  assign accept     = req_valid & req_ready;
  assign fill_acc   = fill_valid & fill_ready;
  assign first_beat = fill_acc & (beat_q == '0);
  assign last_beat  = fill_acc & (beat_q == LAST_BEAT);
  assign fill_word  = m_word + beat_q;

  icache_lfsr u_lfsr (
    .clk  (clk),
    .rst  (rst),
    .pick (lfsr_pick)
  );

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    logic wsel_vic_c, wsel_vic_q;
    assign wsel_vic_c = (vic_c == 1'(w));
    assign wsel_vic_q = (vic_q == 1'(w));

    icache_tag_ram #(.TAG_W(TAG_W), .SETS(SETS)) u_tag (
      .clk      (clk),
      .rst      (rst),
      .rd_idx   (req_index),
      .rd_valid (t_val[w]),
      .rd_tag   (t_tag[w]),
      .rd_mode  (t_mode[w]),
      .rd_perr  (t_perr[w]),
      .wr_en    (accept & ~any_hit & wsel_vic_c),
      .wr_idx   (req_index),
      .wr_tag   (req_ptag),
      .wr_mode  (req_mode),
      .vset_en  (last_beat & wsel_vic_q),
      .vset_idx (m_idx),
      .vclr_en  (accept & (bad[w] | (~any_hit & wsel_vic_c))),
      .vclr_idx (req_index),
      .clr_all  (inv_all),
      .flip_en  (inj_valid & ~inj_data_sel & (inj_way == 1'(w))),
      .flip_idx (inj_index)
    );

    icache_data_ram #(.SETS(SETS), .WORDS(WORDS)) u_data (
      .clk       (clk),
      .rd_addr   ({req_index, req_word}),
      .rd_data   (d_word[w]),
      .rd_perr   (d_perr[w]),
      .wr_en     (fill_acc & wsel_vic_q),
      .wr_addr   ({m_idx, fill_word}),
      .wr_data   (fill_data),
      .flip_en   (inj_valid & inj_data_sel & (inj_way == 1'(w))),
      .flip_addr ({inj_index, inj_word})
    );

    assign match[w] = t_val[w] & (t_tag[w] == req_ptag) & (t_mode[w] == req_mode);
    assign bad[w]   = (t_val[w] & t_perr[w]) | (match[w] & d_perr[w]);
    assign hit_w[w] = match[w] & ~bad[w];
  end

  assign any_hit  = |hit_w;
  assign hit_data = hit_w[0] ? d_word[0] : d_word[1];

  always_comb begin
    if (!(t_val[0] & ~bad[0]))      vic_c = 1'b0;
    else if (!(t_val[1] & ~bad[1])) vic_c = 1'b1;
    else                            vic_c = lfsr_pick;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      beat_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= (accept & any_hit) | first_beat;
      if (accept & any_hit) rsp_data_q <= hit_data;
      else if (first_beat)  rsp_data_q <= fill_data;
      case (st_q)
        ST_IDLE: if (accept & ~any_hit) begin
          st_q   <= ST_MREQ;
          m_idx  <= req_index;
          m_word <= req_word;
          m_tag  <= req_ptag;
          m_mode <= req_mode;
          vic_q  <= vic_c;
        end
        ST_MREQ: if (mem_req_ready) begin
          st_q   <= ST_FILL;
          beat_q <= '0;
        end
        ST_FILL: if (fill_valid) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == LAST_BEAT) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic unused_mode;
  assign unused_mode = ^m_mode;
endmodule

// File: rtl/icache_ctrl_chk.sv
module icache_ctrl_chk #(
  parameter int TAG_W = 20,
  parameter int SETS  = 64,
  parameter int WORDS = 16
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic                                 req_valid,
  input logic                                 req_ready,
  input logic                                 rsp_valid,
  input logic [31:0]                          rsp_data,
  input logic                                 mem_req_valid,
  input logic                                 mem_req_ready,
  input logic [TAG_W+$clog2(SETS)+$clog2(WORDS)+1:0] mem_req_addr,
  input logic                                 fill_valid,
  input logic                                 fill_ready,
  input logic [31:0]                          fill_data
);
  localparam int CNT_W = $clog2(WORDS) + 1;

  logic [CNT_W-1:0] beats_q;
  logic             fill_acc, first_beat;

  assign fill_acc   = fill_valid & fill_ready;
  assign first_beat = fill_acc & (beats_q == '0);

  always_ff @(posedge clk) begin
    if (rst)                                beats_q <= '0;
    else if (mem_req_valid & mem_req_ready) beats_q <= '0;
    else if (fill_acc)                      beats_q <= beats_q + 1'b1;
  end

  // R2
  mreq_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R2
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid || fill_ready) |-> !req_ready);

  // R4
  crit_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    first_beat |=> rsp_valid && rsp_data == $past(fill_data));

  // R1
  rsp_src_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> ($past(req_valid && req_ready) || $past(first_beat)));

  // R3
  beat_cap_chk: assert property (@(posedge clk) disable iff (rst)
    fill_acc |-> beats_q < CNT_W'(WORDS));
endmodule

bind icache_ctrl icache_ctrl_chk #(.TAG_W(TAG_W), .SETS(SETS), .WORDS(WORDS)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_data      (rsp_data),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .fill_valid    (fill_valid),
  .fill_ready    (fill_ready),
  .fill_data     (fill_data)
);

// File: tb/icache_ctrl_tb_top.sv
`timescale 1ns/1ps
module icache_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        inv_all;
  logic        req_valid;
  logic        req_ready;
  logic [5:0]  req_index;
  logic [3:0]  req_word;
  logic [19:0] req_ptag;
  logic [1:0]  req_mode;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        fill_valid;
  logic        fill_ready;
  logic [31:0] fill_data;
  logic        inj_valid, inj_data_sel, inj_way;
  logic [5:0]  inj_index;
  logic [3:0]  inj_word;

  int nchecks = 0, nfail = 0, misses = 0, cyc = 0, b0cyc = 0;
  bit expecting = 0, done = 0;
  logic [31:0] last_addr;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  icache_ctrl dut_i (.*);

  function automatic logic [31:0] memw(logic [19:0] t, logic [5:0] ix, logic [3:0] w);
    logic [31:0] a;
    a = {t, ix, w, 2'b00};
    return (a * 32'h9E3779B1) ^ {a[15:0], a[31:16]};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    nchecks++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
    $finish;
  endtask

  // every-clock comparison: a response may only appear while one is awaited
  always @(negedge clk) begin
    if (!rst && rsp_valid && !expecting)
      chk(0, "R1", "unexpected rsp_valid", 32'd1, 32'd0);
  end

  // memory side: wrapped beats with gaps
  initial begin
    logic [31:0] cap;
    mem_req_ready = 0; fill_valid = 0; fill_data = 0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        cap = mem_req_addr;
        mem_req_ready = 1;
        @(negedge clk);
        mem_req_ready = 0;
        last_addr = cap;
        misses++;
        for (int k = 0; k < 16; k++) begin
          if (k % 5 == 2) begin fill_valid = 0; @(negedge clk); end
          fill_valid = 1;
          fill_data  = memw(cap[31:12], cap[11:6], cap[5:2] + 4'(k));
          while (!fill_ready) @(negedge clk);
          chk(req_ready == 0, "R2", "req_ready during fill", 32'(req_ready), 32'd0);
          @(negedge clk);
          if (k == 0) b0cyc = cyc;
        end
        fill_valid = 0;
      end
    end
  end

  task automatic fetch(input logic [19:0] t, input logic [5:0] ix, input logic [3:0] w,
                       input logic [1:0] md, output bit hit);
    int m0, lat, rc;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_ptag = t; req_index = ix; req_word = w; req_mode = md;
    m0 = misses; expecting = 1;
    @(negedge clk);
    req_valid = 0; lat = 1;
    while (!rsp_valid) begin @(negedge clk); lat++; end
    rc = cyc;
    chk(rsp_data == memw(t, ix, w), "R1/R4", "fetch data", rsp_data, memw(t, ix, w));
    hit = (misses == m0);
    if (hit) chk(lat == 1, "R1", "hit latency", 32'(lat), 32'd1);
    else begin
      chk(rc == b0cyc, "R4", "critical word forward cycle", 32'(rc), 32'(b0cyc));
      chk(last_addr == {t, ix, w, 2'b00}, "R2", "line request address", last_addr, {t, ix, w, 2'b00});
    end
    #1 expecting = 0;
  endtask

  task automatic expect_fetch(input logic [19:0] t, input logic [5:0] ix, input logic [3:0] w,
                              input logic [1:0] md, input bit exp_hit, input string req);
    bit h;
    fetch(t, ix, w, md, h);
    chk(h == exp_hit, req, "hit/miss outcome", 32'(h), 32'(exp_hit));
  endtask

  task automatic inject(input bit dsel, input bit way, input logic [5:0] ix, input logic [3:0] w);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    inj_valid = 1; inj_data_sel = dsel; inj_way = way; inj_index = ix; inj_word = w;
    @(negedge clk);
    inj_valid = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchecks++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    bit h;
    int ev_old1 = 0, ev_old2 = 0;
    rst = 1; inv_all = 0; req_valid = 0; req_index = 0; req_word = 0; req_ptag = 0; req_mode = 0;
    inj_valid = 0; inj_data_sel = 0; inj_way = 0; inj_index = 0; inj_word = 0;
    repeat (5) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    // R11 reset state
    chk(req_ready == 1, "R11", "req_ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 0, "R11", "rsp_valid", 32'(rsp_valid), 32'd0);
    chk(mem_req_valid == 0, "R11", "mem_req_valid", 32'(mem_req_valid), 32'd0);

    // R2 R4 cold miss with a mid-line critical word
    expect_fetch(20'h00111, 6'd5, 4'd9, 2'd0, 0, "R2");
    // R3 every word of the wrapped fill
    for (int w = 0; w < 16; w++) expect_fetch(20'h00111, 6'd5, 4'(w), 2'd0, 1, "R3");

    // R5 mode is part of the match, R6 empty way used first
    expect_fetch(20'h00111, 6'd5, 4'd2, 2'd1, 0, "R5");
    expect_fetch(20'h00111, 6'd5, 4'd15, 2'd0, 1, "R6");
    expect_fetch(20'h00111, 6'd5, 4'd0, 2'd1, 1, "R5");

    // R7 random victim in full sets
    for (int s = 10; s < 26; s++) begin
      expect_fetch(20'h01000, 6'(s), 4'd3, 2'd0, 0, "R7");
      expect_fetch(20'h02000, 6'(s), 4'd7, 2'd0, 0, "R6");
      expect_fetch(20'h03000, 6'(s), 4'd12, 2'd0, 0, "R7");
      expect_fetch(20'h03000, 6'(s), 4'd1, 2'd0, 1, "R7");
      fetch(20'h01000, 6'(s), 4'd4, 2'd0, h);
      if (h) begin
        ev_old2++;
        expect_fetch(20'h02000, 6'(s), 4'd4, 2'd0, 0, "R7");
      end else ev_old1++;
    end
    chk(ev_old1 > 0 && ev_old2 > 0, "R7", "both ways chosen as victim",
        32'(ev_old1), 32'(ev_old2));

    // R8 tag parity error
    expect_fetch(20'h0ABCD, 6'd40, 4'd0, 2'd2, 0, "R8");
    expect_fetch(20'h0ABCD, 6'd40, 4'd7, 2'd2, 1, "R8");
    inject(0, 0, 6'd40, 4'd0);
    expect_fetch(20'h0ABCD, 6'd40, 4'd7, 2'd2, 0, "R8");
    expect_fetch(20'h0ABCD, 6'd40, 4'd7, 2'd2, 1, "R8");

    // R9 data parity error
    inject(1, 0, 6'd40, 4'd7);
    expect_fetch(20'h0ABCD, 6'd40, 4'd8, 2'd2, 1, "R9");
    expect_fetch(20'h0ABCD, 6'd40, 4'd7, 2'd2, 0, "R9");
    expect_fetch(20'h0ABCD, 6'd40, 4'd7, 2'd2, 1, "R9");

    // R10 invalidate all
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    inv_all = 1;
    @(negedge clk);
    inv_all = 0;
    expect_fetch(20'h00111, 6'd5, 4'd9, 2'd0, 0, "R10");
    expect_fetch(20'h0ABCD, 6'd40, 4'd7, 2'd2, 0, "R10");

    repeat (20) @(negedge clk);
    summary();
  end
endmodule